// File: doc/BRIEF.md
# DS3 C-bit Parity Transmit Overhead Inserter

This block sits on the transmit side of a DS3 path. It takes a serial payload stream, one bit per clock qualified by a valid strobe, and rewrites every overhead slot of the 4760-bit C-bit parity M-frame as the bits pass through. It keeps its own frame position, so the bits it receives are counted from reset: the first accepted bit becomes the X1 slot. Each overhead slot is filled with a fixed alignment pattern, with the payload parity of the previous frame, or with a programmed or AIS-forced value. The serial result leaves one cycle later together with a frame-start strobe.

The frame has 7 subframes. Each subframe has 8 blocks of 85 bits, and each block is one overhead bit followed by 84 payload bits. In every subframe the block-head slots run in this order: lead bit, F1, C1, F2, C2, F3, C3, F4. The lead bit of subframes 1 to 7 is X1, X2, P1, P2, M1, M2, M3. Two request inputs replace the payload. An idle request sends a 1100 pattern. An AIS request sends a 1010 pattern and also forces X bits and non-parity C-bits. AIS wins when both requests are high.

Top module: `ds3_cbit_oh_insert`

## Requirements
- R1: Each cycle with `in_valid` high produces exactly one output bit on the next cycle with `out_valid` high. A cycle with `in_valid` low gives `out_valid` low on the next cycle and does not advance the frame position.
- R2: The frame is 4760 accepted bits. Position 0 of each 85-bit block is an overhead slot. In normal mode the other 84 positions carry `in_bit` unchanged.
- R3: M1, M2 and M3 (lead bits of subframes 5, 6, 7) are sent as 0, 1, 0 in every mode.
- R4: F1, F2, F3 and F4 (blocks 2, 4, 6, 8 of every subframe) are sent as 1, 0, 0, 1 in every mode.
- R5: P1, P2, C31, C32 and C33 all carry the XOR of every payload bit sent in the previous frame, in every mode. In the first frame after reset they are 0.
- R6: Without AIS, X1 = `cfg_x[0]` and X2 = `cfg_x[1]`. C11 = `cfg_c[0]`, C13 = `cfg_c[1]`, C41..C43 = `cfg_c[2..4]` and C51..C53 = `cfg_c[5..7]`. C12, C21..C23, C61..C63 and C71..C73 are sent as 1.
- R7: With `ais_req` high for a bit, an X slot is sent as 1 and a C slot outside subframe 3 is sent as 0. A payload bit at block offset k (1..84) is sent as 1 for odd k and 0 for even k.
- R8: With `idle_req` high and `ais_req` low for a bit, a payload bit at block offset k is sent as 1 when (k-1) mod 4 is 0 or 1 and as 0 otherwise. Overhead follows normal mode.
- R9: When `ais_req` and `idle_req` are both high, the bit follows the AIS rule of R7. The requests are sampled bit by bit, so a frame may mix modes.
- R10: `out_sof` is high for exactly the output cycle that carries X1 and is low on all other cycles.
- R11: While reset is asserted and after it is released, `out_valid` and `out_sof` are low until the first accepted bit. That first accepted bit is sent as X1 of a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_bit | input | 1 | Payload bit in |
| in_valid | input | 1 | Qualifies `in_bit` and advances the frame position |
| ais_req | input | 1 | Send the AIS pattern for this bit |
| idle_req | input | 1 | Send the idle pattern for this bit |
| cfg_x | input | 2 | Programmed X1 (bit 0) and X2 (bit 1) |
| cfg_c | input | 8 | Programmed C11, C13, C41..C43, C51..C53 (bits 0..7) |
| out_bit | output | 1 | Serial stream with overhead inserted |
| out_valid | output | 1 | Qualifies `out_bit` |
| out_sof | output | 1 | Frame start, coincides with X1 |

## Verification
The in-line assertions check several properties on every cycle:
- a stalled input cycle leaves the frame position unchanged;
- the latched parity changes only at the frame boundary;
- `out_valid` follows `in_valid` one cycle later;
- `out_sof` never lasts two cycles and never appears without `out_valid`;
- M slots always carry their fixed values;
- X slots always carry 1 under AIS.

Other behaviours need complete frames from the bench's scenarios:
- the parity carried from one frame into the next;
- the mapping of programmed C-bit values;
- the idle and AIS payload patterns;
- AIS overriding idle when the requests change partway through a frame.

// File: rtl/ds3_ohi_pkg.sv
package ds3_ohi_pkg;
  localparam int unsigned SUBF_N   = 7;
  localparam int unsigned BLK_N    = 8;
  localparam int unsigned BLK_BITS = 85;
  localparam int unsigned CFG_C_W  = 8;
  localparam int unsigned CFG_X_W  = 2;

  typedef enum logic [2:0] {
    SLOT_PAY = 3'd0,
    SLOT_X   = 3'd1,
    SLOT_P   = 3'd2,
    SLOT_M   = 3'd3,
    SLOT_F   = 3'd4,
    SLOT_C   = 3'd5
  } slot_kind_e;
endpackage

// File: rtl/ds3_frame_pos.sv
module ds3_frame_pos #(
  parameter int unsigned SUBF_N   = ds3_ohi_pkg::SUBF_N,
  parameter int unsigned BLK_N    = ds3_ohi_pkg::BLK_N,
  parameter int unsigned BLK_BITS = ds3_ohi_pkg::BLK_BITS,
  localparam int unsigned SW = $clog2(SUBF_N),
  localparam int unsigned BW = $clog2(BLK_N),
  localparam int unsigned PW = $clog2(BLK_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [SW-1:0] sub,
  output logic [BW-1:0] blk,
  output logic [PW-1:0] pos,
  output logic          frame_last
);
  logic [SW-1:0] sub_d;
  logic [BW-1:0] blk_d;
  logic [PW-1:0] pos_d;
  logic          pos_wrap, blk_wrap, sub_wrap;

  always_comb begin
    pos_wrap   = (pos == PW'(BLK_BITS - 1));
    blk_wrap   = (blk == BW'(BLK_N - 1));
    sub_wrap   = (sub == SW'(SUBF_N - 1));
    frame_last = pos_wrap && blk_wrap && sub_wrap;
    pos_d = pos;
    blk_d = blk;
    sub_d = sub;
    if (adv) begin
      pos_d = pos_wrap ? '0 : pos + PW'(1);
      if (pos_wrap) begin
        blk_d = blk_wrap ? '0 : blk + BW'(1);
        if (blk_wrap) sub_d = sub_wrap ? '0 : sub + SW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
      blk <= '0;
      sub <= '0;
    end else begin
      pos <= pos_d;
      blk <= blk_d;
      sub <= sub_d;
    end
  end

  // R1: a stalled cycle leaves the frame position untouched
  p_pos_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable({sub, blk, pos}));
endmodule

// File: rtl/ds3_parity_acc.sv
module ds3_parity_acc (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic is_payload,
  input  logic tx_bit,
  input  logic frame_last,
  output logic par_q
);
  logic acc_q, acc_next, acc_d, par_d, frame_end;

  always_comb begin
    frame_end = adv && frame_last;
    acc_next  = acc_q ^ (adv && is_payload && tx_bit);
    acc_d     = frame_end ? 1'b0 : acc_next;
    par_d     = frame_end ? acc_next : par_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      par_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      par_q <= par_d;
    end
  end

  // R5: the carried parity only changes at a frame boundary
  p_par_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv && frame_last) |=> $stable(par_q));
endmodule

// File: rtl/ds3_oh_select.sv
module ds3_oh_select
  import ds3_ohi_pkg::*;
#(
  parameter int unsigned SUBF_N   = ds3_ohi_pkg::SUBF_N,
  parameter int unsigned BLK_N    = ds3_ohi_pkg::BLK_N,
  parameter int unsigned BLK_BITS = ds3_ohi_pkg::BLK_BITS,
  localparam int unsigned SW = $clog2(SUBF_N),
  localparam int unsigned BW = $clog2(BLK_N),
  localparam int unsigned PW = $clog2(BLK_BITS)
) (
  input  logic [SW-1:0]      sub,
  input  logic [BW-1:0]      blk,
  input  logic [PW-1:0]      pos,
  input  logic               in_bit,
  input  logic               ais,
  input  logic               idle,
  input  logic               par,
  input  logic [CFG_X_W-1:0] cfg_x,
  input  logic [CFG_C_W-1:0] cfg_c,
  output logic               tx_bit,
  output logic               is_payload
);
  slot_kind_e kind;
  logic [PW-1:0] pm1;
  logic [1:0]    cidx;
  logic          c_norm;

  always_comb begin
    kind = SLOT_PAY;
    if (pos == '0) begin
      if (blk == '0) begin
        if (sub < SW'(2))      kind = SLOT_X;
        else if (sub < SW'(4)) kind = SLOT_P;
        else                   kind = SLOT_M;
      end else if (blk[0]) begin
        kind = SLOT_F;
      end else begin
        kind = SLOT_C;
      end
    end
  end

  always_comb begin
    cidx   = 2'(blk[BW-1:1] - 1'b1);
    c_norm = 1'b1;
    case (sub)
      SW'(0): case (cidx)
        2'd0:    c_norm = cfg_c[0];
        2'd2:    c_norm = cfg_c[1];
        default: c_norm = 1'b1;
      endcase
      SW'(3): case (cidx)
        2'd0:    c_norm = cfg_c[2];
        2'd1:    c_norm = cfg_c[3];
        default: c_norm = cfg_c[4];
      endcase
      SW'(4): case (cidx)
        2'd0:    c_norm = cfg_c[5];
        2'd1:    c_norm = cfg_c[6];
        default: c_norm = cfg_c[7];
      endcase
      default: c_norm = 1'b1;
    endcase
  end

  always_comb begin
    pm1        = pos - PW'(1);
    is_payload = (kind == SLOT_PAY);
    tx_bit     = in_bit;
    unique case (kind)
      SLOT_PAY: begin
        if (ais)       tx_bit = pos[0];
        else if (idle) tx_bit = ~pm1[1];
        else           tx_bit = in_bit;
      end
      SLOT_X: tx_bit = ais ? 1'b1 : cfg_x[sub[0]];
      SLOT_P: tx_bit = par;
      SLOT_M: tx_bit = (sub == SW'(5));
      SLOT_F: tx_bit = (blk == BW'(1)) || (blk == BW'(BLK_N - 1));
      SLOT_C: begin
        if (sub == SW'(2)) tx_bit = par;
        else if (ais)      tx_bit = 1'b0;
        else               tx_bit = c_norm;
      end
      default: tx_bit = in_bit;
    endcase
  end
endmodule

// File: rtl/ds3_cbit_oh_insert.sv
module ds3_cbit_oh_insert
  import ds3_ohi_pkg::*;
#(
  parameter int unsigned SUBF_N   = ds3_ohi_pkg::SUBF_N,
  parameter int unsigned BLK_N    = ds3_ohi_pkg::BLK_N,
  parameter int unsigned BLK_BITS = ds3_ohi_pkg::BLK_BITS,
  localparam int unsigned SW = $clog2(SUBF_N),
  localparam int unsigned BW = $clog2(BLK_N),
  localparam int unsigned PW = $clog2(BLK_BITS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_bit,
  input  logic               in_valid,
  input  logic               ais_req,
  input  logic               idle_req,
  input  logic [CFG_X_W-1:0] cfg_x,
  input  logic [CFG_C_W-1:0] cfg_c,
  output logic               out_bit,
  output logic               out_valid,
  output logic               out_sof
);
  logic          rst_meta, core_rst_n;
  logic [SW-1:0] sub;
  logic [BW-1:0] blk;
  logic [PW-1:0] pos;
  logic          frame_last, par_q, tx_bit, is_payload;
  logic          at_head, at_x, at_m;
  logic          out_bit_d, out_valid_d, out_sof_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      core_rst_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      core_rst_n <= rst_meta;
    end
  end

  ds3_frame_pos #(.SUBF_N(SUBF_N), .BLK_N(BLK_N), .BLK_BITS(BLK_BITS)) u_pos (
    .clk(clk), .rst_n(core_rst_n), .adv(in_valid),
    .sub(sub), .blk(blk), .pos(pos), .frame_last(frame_last)
  );

  ds3_oh_select #(.SUBF_N(SUBF_N), .BLK_N(BLK_N), .BLK_BITS(BLK_BITS)) u_sel (
    .sub(sub), .blk(blk), .pos(pos), .in_bit(in_bit), .ais(ais_req),
    .idle(idle_req), .par(par_q), .cfg_x(cfg_x), .cfg_c(cfg_c),
    .tx_bit(tx_bit), .is_payload(is_payload)
  );

  ds3_parity_acc u_par (
    .clk(clk), .rst_n(core_rst_n), .adv(in_valid), .is_payload(is_payload),
    .tx_bit(tx_bit), .frame_last(frame_last), .par_q(par_q)
  );

  always_comb begin
    at_head     = (pos == '0) && (blk == '0);
    at_x        = at_head && (sub < SW'(2));
    at_m        = at_head && (sub >= SW'(4));
    out_valid_d = in_valid;
    out_sof_d   = in_valid && at_head && (sub == '0);
    out_bit_d   = in_valid ? tx_bit : out_bit;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      out_bit   <= 1'b0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
    end else begin
      out_bit   <= out_bit_d;
      out_valid <= out_valid_d;
      out_sof   <= out_sof_d;
    end
  end

  // R1: every accepted bit leaves one cycle later
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!core_rst_n)
    in_valid |=> out_valid);
  // R10: frame start is a single qualified cycle
  p_sof_single_r10: assert property (@(posedge clk) disable iff (!core_rst_n)
    out_sof |-> out_valid ##1 !out_sof);
  // R7: X slots under AIS are sent as one
  p_ais_x_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (in_valid && ais_req && at_x) |=> out_bit);
  // R3: M slots follow 0,1,0
  p_mbit_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
    (in_valid && at_m) |=> (out_bit == $past(sub == SW'(5))));
endmodule

// File: tb/ds3_cbit_oh_insert_test.sv
module ds3_cbit_oh_insert_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_bit = 1'b0, in_valid = 1'b0, ais_req = 1'b0, idle_req = 1'b0;
  logic [1:0] cfg_x = 2'b00;
  logic [7:0] cfg_c = 8'h00;
  logic       out_bit, out_valid, out_sof;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  // independent model state
  int  m_sub = 0, m_blk = 0, m_pos = 0;
  bit  m_par = 0, m_acc = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  ds3_cbit_oh_insert uut (
    .clk(clk), .rst_n(rst_n), .in_bit(in_bit), .in_valid(in_valid),
    .ais_req(ais_req), .idle_req(idle_req), .cfg_x(cfg_x), .cfg_c(cfg_c),
    .out_bit(out_bit), .out_valid(out_valid), .out_sof(out_sof)
  );

  task automatic chk(input bit ok, input string req, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at sub=%0d blk=%0d pos=%0d: actual=%0b expected=%0b",
               req, m_sub, m_blk, m_pos, act, exp);
    end
  endtask

  function automatic bit cbit_exp(int s, int ci, bit a);
    if (s == 2) return m_par;
    if (a) return 1'b0;
    case (s)
      0: return (ci == 0) ? cfg_c[0] : (ci == 2) ? cfg_c[1] : 1'b1;
      3: return cfg_c[2 + ci];
      4: return cfg_c[5 + ci];
      default: return 1'b1;
    endcase
  endfunction

  // expected bit and requirement tag for the current model position
  task automatic model(input bit d, input bit a, input bit i, output bit e, output string r);
    if (m_pos != 0) begin
      if (a)      begin e = m_pos[0];                      r = i ? "R9" : "R7"; end
      else if (i) begin e = (((m_pos - 1) % 4) < 2);       r = "R8"; end
      else        begin e = d;                             r = "R2"; end
    end else if (m_blk == 0) begin
      case (m_sub)
        0: begin e = a ? 1'b1 : cfg_x[0]; r = a ? "R7" : "R6"; end
        1: begin e = a ? 1'b1 : cfg_x[1]; r = a ? "R7" : "R6"; end
        2, 3: begin e = m_par; r = "R5"; end
        default: begin e = (m_sub == 5); r = "R3"; end
      endcase
    end else if (m_blk % 2 == 1) begin
      e = (m_blk == 1 || m_blk == 7); r = "R4";
    end else begin
      e = cbit_exp(m_sub, m_blk / 2 - 1, a);
      r = (m_sub == 2) ? "R5" : (a ? "R7" : "R6");
    end
  endtask

  task automatic step(input bit d, input bit v, input bit a, input bit i);
    bit e; string r;
    in_bit = d; in_valid = v; ais_req = a; idle_req = i;
    @(negedge clk);
    if (!v) begin
      chk(out_valid == 1'b0, "R1", out_valid, 1'b0);
      return;
    end
    model(d, a, i, e, r);
    chk(out_valid == 1'b1, "R1", out_valid, 1'b1);
    chk(out_bit == e, r, out_bit, e);
    chk(out_sof == (m_sub == 0 && m_blk == 0 && m_pos == 0), "R10", out_sof,
        (m_sub == 0 && m_blk == 0 && m_pos == 0));
    if (m_pos != 0) m_acc ^= e;
    if (m_pos == 84) begin
      m_pos = 0;
      if (m_blk == 7) begin
        m_blk = 0;
        if (m_sub == 6) begin m_sub = 0; m_par = m_acc; m_acc = 0; end
        else m_sub++;
      end else m_blk++;
    end else m_pos++;
  endtask

  function automatic bit next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic test_reset();
    chk(out_valid == 1'b0, "R11", out_valid, 1'b0);
    chk(out_sof == 1'b0, "R11", out_sof, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    chk(out_sof == 1'b0, "R11", out_sof, 1'b0);
  endtask

  // R1 R2 R6: normal frame with random payload and valid gaps
  task automatic test_normal(input logic [1:0] x, input logic [7:0] c);
    cfg_x = x; cfg_c = c;
    for (int n = 0; n < 4760; n++) begin
      if (n % 37 == 5) step(1'b1, 1'b0, 1'b0, 1'b0);
      step(next_rand(), 1'b1, 1'b0, 1'b0);
    end
  endtask

  // R5: single one gives odd parity, then an all-zero frame gives even parity
  task automatic test_parity();
    for (int n = 0; n < 4760; n++) step(n == 300, 1'b1, 1'b0, 1'b0);
    for (int n = 0; n < 4760; n++) step(1'b0, 1'b1, 1'b0, 1'b0);
    for (int n = 0; n < 4760; n++) step(1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  // R7: full AIS frame
  task automatic test_ais();
    for (int n = 0; n < 4760; n++) step(next_rand(), 1'b1, 1'b1, 1'b0);
  endtask

  // R8: full idle frame
  task automatic test_idle();
    for (int n = 0; n < 4760; n++) step(next_rand(), 1'b1, 1'b0, 1'b1);
  endtask

  // R9: idle held high, AIS toggling partway through frames
  task automatic test_ais_over_idle();
    for (int n = 0; n < 9520; n++) step(next_rand(), 1'b1, (n / 1000) % 2 == 0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    test_reset();
    test_normal(2'b01, 8'hA5);
    test_normal(2'b10, 8'h5A);
    test_parity();
    test_ais();
    test_idle();
    test_ais_over_idle();
    test_normal(2'b11, 8'h3C);
    done = 1;
  end

  initial begin
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule